// File: doc/BRIEF.md
# Chainable Serial Stereo Gain Port

This block receives gain settings for a two-channel volume stage over a three-wire serial link made of an active-low select, a serial clock and a data line. While the select is held low, each rising edge of the serial clock moves one data bit into a 16-bit shift register. When the select is released after a complete word, the block presents two 8-bit gain codes to the downstream gain logic and pulses a one-cycle update strobe. A code of 0x00 means mute, and that is the value both channels hold after reset.

The bit that leaves the top of the shift register is driven out on a serial output on each falling edge of the serial clock. Several units can therefore share one select and one clock line, with each unit's output wired to the next unit's data input. The chain then acts as one long shift register of 16 bits per unit, and the host keeps the select low for 16 clock periods per unit. The output carries a separate enable. The enable is low while the unit is deselected, so the pad is high-impedance then.

All three serial pins are asynchronous to the system clock. Each passes through a two-flop synchroniser, and the block detects serial-clock edges and select edges in the system clock domain. The system clock must run fast enough that the shortest serial-clock high or low pulse spans several system cycles.

Top module: `gain_serial_port`

## Requirements
- R1: After reset, gain_right_o and gain_left_o are 0x00 (mute), gain_upd_o is 0 and sdo_oe_o is 0.
- R2: A data bit is taken only on a rising serial-clock edge while the select is low. Serial-clock activity while csn_i is high leaves the shift register, the gains and the serial output unchanged.
- R3: In a 16-bit word, the first 8 bits form the right-channel code and the next 8 bits form the left-channel code, each most significant bit first. The gain outputs change only together with a gain_upd_o pulse.
- R4: If more than 16 bits are sent in one select period, the last 16 bits before the select rises are committed.
- R5: If fewer than 16 bits are sent in one select period, the gains are not changed and no update pulse is produced.
- R6: gain_upd_o is high for exactly one system clock per committed word. It rises at the third system clock edge, counting as the first the edge that samples csn_i high. The output enable is already low in that cycle.
- R7: sdo_oe_o follows the inverse of csn_i delayed by two system clocks. In particular, it is low two cycles after csn_i is sampled high.
- R8: While selected, sdo_o takes the current top bit of the shift register at the select's falling edge and on every falling serial-clock edge. The serial output therefore repeats the input stream delayed by 16 bits. sdo_o does not change while the unit is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csn_i | input | 1 | Serial select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data in |
| gain_right_o | output | 8 | Committed right-channel gain code |
| gain_left_o | output | 8 | Committed left-channel gain code |
| gain_upd_o | output | 1 | One-cycle strobe when a new gain pair is committed |
| sdo_o | output | 1 | Serial data out to the next unit in the chain |
| sdo_oe_o | output | 1 | Output enable for sdo_o; pad is high-impedance when low |

## Verification
The assertions check the following on every cycle:
- the strobe never lasts longer than one cycle;
- the gains never move without the strobe;
- the strobe only fires while the output enable is low;
- the enable drops two cycles after the select is seen high;
- the serial output stays frozen while the unit is deselected.

Only the bench scenarios can show the rest:
- the byte order and bit order of a word;
- that the last 16 bits of an over-long word win;
- that a short word is discarded;
- the exact cycle of the strobe;
- that the serial output replays the input 16 bits later, including bits held over from an earlier word and left untouched by serial-clock toggles while deselected.

// File: rtl/gsp_pkg.sv
package gsp_pkg;
  localparam int unsigned DEF_GAIN_W      = 8;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned NUM_CHAN        = 2;

  // counter width able to hold 0..n
  function automatic int unsigned cnt_w(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/gsp_sync.sv
module gsp_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gsp_front.sv
module gsp_front #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic csn_i,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic sel_o,
  output logic sel_start_o,
  output logic sel_end_o,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic sdi_o
);
  localparam int unsigned PIN_N = 3;
  localparam int unsigned CSN_B = 2;
  localparam int unsigned SCK_B = 1;
  localparam int unsigned SDI_B = 0;

  logic [PIN_N-1:0] pin_raw, pin_syn;
  logic csn_d, sclk_d;

  assign pin_raw = {csn_i, sclk_i, sdi_i};

  gsp_sync #(
    .W      (PIN_N),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_raw),
    .q_o   (pin_syn)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csn_d  <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      csn_d  <= pin_syn[CSN_B];
      sclk_d <= pin_syn[SCK_B];
    end
  end

  assign sel_o       = ~pin_syn[CSN_B];
  assign sel_start_o = csn_d & ~pin_syn[CSN_B];
  assign sel_end_o   = ~csn_d & pin_syn[CSN_B];
  assign sclk_rise_o = sel_o & pin_syn[SCK_B] & ~sclk_d;
  assign sclk_fall_o = sel_o & ~pin_syn[SCK_B] & sclk_d;
  assign sdi_o       = pin_syn[SDI_B];
endmodule

// File: rtl/gsp_shifter.sv
module gsp_shifter #(
  parameter int unsigned FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sel_start_i,
  input  logic               shift_i,
  input  logic               drive_i,
  input  logic               sdi_i,
  output logic [FRAME_W-1:0] word_o,
  output logic               full_o,
  output logic               sdo_o
);
  localparam int unsigned CNT_W = gsp_pkg::cnt_w(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
    end else if (shift_i) begin
      sh_q <= {sh_q[FRAME_W-2:0], sdi_i};
    end
  end

  // bit count of the current select period, saturating at one word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (sel_start_i) begin
      cnt_q <= '0;
    end else if (shift_i && cnt_q != CNT_FULL) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // overflow bit leaves on the opposite serial edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sdo_q <= 1'b0;
    end else if (sel_start_i || drive_i) begin
      sdo_q <= sh_q[FRAME_W-1];
    end
  end

  assign word_o = sh_q;
  assign full_o = (cnt_q == CNT_FULL);
  assign sdo_o  = sdo_q;
endmodule

// File: rtl/gsp_commit.sv
module gsp_commit #(
  parameter int unsigned GAIN_W = 8,
  localparam int unsigned FRAME_W = gsp_pkg::NUM_CHAN * GAIN_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sel_end_i,
  input  logic               full_i,
  input  logic [FRAME_W-1:0] word_i,
  output logic [GAIN_W-1:0]  gain_right_o,
  output logic [GAIN_W-1:0]  gain_left_o,
  output logic               upd_o
);
  logic take;
  assign take = sel_end_i & full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_right_o <= '0;
      gain_left_o  <= '0;
      upd_o        <= 1'b0;
    end else begin
      upd_o <= take;
      if (take) begin
        // first byte shifted in sits in the upper half
        gain_right_o <= word_i[FRAME_W-1:GAIN_W];
        gain_left_o  <= word_i[GAIN_W-1:0];
      end
    end
  end
endmodule

// File: rtl/gain_serial_port.sv
module gain_serial_port #(
  parameter int unsigned GAIN_W      = gsp_pkg::DEF_GAIN_W,
  parameter int unsigned SYNC_STAGES = gsp_pkg::DEF_SYNC_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic [GAIN_W-1:0] gain_right_o,
  output logic [GAIN_W-1:0] gain_left_o,
  output logic              gain_upd_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int unsigned FRAME_W = gsp_pkg::NUM_CHAN * GAIN_W;

  logic sel, sel_start, sel_end, sclk_rise, sclk_fall, sdi_s, full;
  logic [FRAME_W-1:0] word;

  gsp_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .csn_i      (csn_i),
    .sclk_i     (sclk_i),
    .sdi_i      (sdi_i),
    .sel_o      (sel),
    .sel_start_o(sel_start),
    .sel_end_o  (sel_end),
    .sclk_rise_o(sclk_rise),
    .sclk_fall_o(sclk_fall),
    .sdi_o      (sdi_s)
  );

  gsp_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_start_i(sel_start),
    .shift_i    (sclk_rise),
    .drive_i    (sclk_fall),
    .sdi_i      (sdi_s),
    .word_o     (word),
    .full_o     (full),
    .sdo_o      (sdo_o)
  );

  gsp_commit #(.GAIN_W(GAIN_W)) u_commit (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_end_i   (sel_end),
    .full_i      (full),
    .word_i      (word),
    .gain_right_o(gain_right_o),
    .gain_left_o (gain_left_o),
    .upd_o       (gain_upd_o)
  );

  assign sdo_oe_o = sel;
endmodule

// File: rtl/gsp_chk.sv
module gsp_chk #(
  parameter int unsigned GAIN_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              csn_i,
  input logic [GAIN_W-1:0] gain_right_o,
  input logic [GAIN_W-1:0] gain_left_o,
  input logic              gain_upd_o,
  input logic              sdo_o,
  input logic              sdo_oe_o
);
  // R7
  oe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(csn_i, 2) |-> !sdo_oe_o);

  // R6
  upd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_upd_o |=> !gain_upd_o);

  // R6
  upd_deselected_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_upd_o |-> !sdo_oe_o);

  // R3
  gain_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gain_upd_o |-> ($stable(gain_right_o) && $stable(gain_left_o)));

  // R8
  sdo_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!sdo_oe_o) |-> $stable(sdo_o));
endmodule

bind gain_serial_port gsp_chk #(.GAIN_W(GAIN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .csn_i       (csn_i),
  .gain_right_o(gain_right_o),
  .gain_left_o (gain_left_o),
  .gain_upd_o  (gain_upd_o),
  .sdo_o       (sdo_o),
  .sdo_oe_o    (sdo_oe_o)
);

// File: tb/sim_gain_serial_port.sv
`timescale 1ns/1ps
module sim_gain_serial_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csn = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [7:0] g_r, g_l;
  logic upd, sdo, sdo_oe;

  int n_cmp = 0;
  int n_bad = 0;
  int upd_cnt = 0;
  bit done = 0;
  logic [63:0] sdo_seen;

  always #4 clk = ~clk;

  gain_serial_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .csn_i(csn), .sclk_i(sclk), .sdi_i(sdi),
    .gain_right_o(g_r), .gain_left_o(g_l), .gain_upd_o(upd),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic cap_rst, cap_c, cap_s, cap_d;
  logic hc[4], hs[4], hd[4];
  bit   q[$];
  int   m_cnt;
  logic m_sdo, m_upd;
  logic [7:0] m_r, m_l;

  always @(posedge clk) begin
    cap_rst = rst_n; cap_c = csn; cap_s = sclk; cap_d = sdi;
  end

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin hc[i] = 1'b1; hs[i] = 1'b0; hd[i] = 1'b0; end
    q.delete();
    for (int i = 0; i < 16; i++) q.push_back(1'b0);
    m_cnt = 0; m_sdo = 1'b0; m_upd = 1'b0; m_r = 8'h00; m_l = 8'h00;
  endtask

  task automatic model_step();
    bit rise, fall, start, fin;
    for (int i = 3; i > 0; i--) begin hc[i] = hc[i-1]; hs[i] = hs[i-1]; hd[i] = hd[i-1]; end
    hc[0] = cap_c; hs[0] = cap_s; hd[0] = cap_d;
    rise  = !hc[2] && hs[2] && !hs[3];
    fall  = !hc[2] && !hs[2] && hs[3];
    start = hc[3] && !hc[2];
    fin   = !hc[3] && hc[2];
    m_upd = fin && (m_cnt == 16);
    if (m_upd) begin
      for (int i = 0; i < 8; i++) begin
        m_r[7-i] = q[i];
        m_l[7-i] = q[8+i];
      end
    end
    if (start) begin m_sdo = q[0]; m_cnt = 0; end
    if (fall) m_sdo = q[0];
    if (rise) begin
      q.push_back(hd[2]);
      void'(q.pop_front());
      if (m_cnt < 16) m_cnt++;
    end
  endtask

  initial model_reset();

  always @(negedge clk) begin
    if (!cap_rst) model_reset();
    else begin
      model_step();
      check("R3 model gain_right", {24'd0, g_r}, {24'd0, m_r});
      check("R3 model gain_left", {24'd0, g_l}, {24'd0, m_l});
      check("R6 model gain_upd", {31'd0, upd}, {31'd0, m_upd});
      check("R7 model sdo_oe", {31'd0, sdo_oe}, {31'd0, !hc[1]});
      check("R8 model sdo", {31'd0, sdo}, {31'd0, m_sdo});
      if (upd) upd_cnt++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic send_bits(input logic [63:0] data, input int n);
    @(negedge clk) csn = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sdi = data[n-1-i];
      repeat (5) @(negedge clk);
      sdo_seen[i] = sdo;
      sclk = 1'b1;
      repeat (10) @(negedge clk);
      sclk = 1'b0;
      repeat (5) @(negedge clk);
    end
    csn = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic idle_clocks(input int n);
    for (int i = 0; i < n; i++) begin
      sdi = 1'b1;
      repeat (10) @(negedge clk) sclk = 1'b1;
      repeat (10) @(negedge clk) sclk = 1'b0;
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    int u0c;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset gain_right", {24'd0, g_r}, 32'h00);
    check("R1 reset gain_left", {24'd0, g_l}, 32'h00);
    check("R1 reset gain_upd", {31'd0, upd}, 32'h0);
    check("R1 reset sdo_oe", {31'd0, sdo_oe}, 32'h0);

    u0c = upd_cnt;
    send_bits(64'hA53C, 16);
    check("R3 right byte", {24'd0, g_r}, 32'hA5);
    check("R3 left byte", {24'd0, g_l}, 32'h3C);
    check("R6 one pulse per word", upd_cnt - u0c, 1);

    u0c = upd_cnt;
    send_bits(64'hFFF, 12);
    check("R5 short word right kept", {24'd0, g_r}, 32'hA5);
    check("R5 short word left kept", {24'd0, g_l}, 32'h3C);
    check("R5 short word no pulse", upd_cnt - u0c, 0);

    // serial-clock toggles while deselected
    idle_clocks(8);
    check("R2 deselected clocks gain_right", {24'd0, g_r}, 32'hA5);
    check("R2 deselected clocks no pulse", upd_cnt - u0c, 0);
    check("R7 deselected oe", {31'd0, sdo_oe}, 32'h0);

    u0c = upd_cnt;
    send_bits(64'h12349E61, 32);
    check("R4 long word right", {24'd0, g_r}, 32'h9E);
    check("R4 long word left", {24'd0, g_l}, 32'h61);
    check("R4 long word one pulse", upd_cnt - u0c, 1);
    // held bits 0xCFFF must come out first untouched by the idle clocks
    for (int i = 0; i < 16; i++)
      check("R2 held bit replay", {31'd0, sdo_seen[i]}, {31'd0, 1'(16'hCFFF >> (15 - i))});
    for (int i = 16; i < 32; i++)
      check("R8 delayed replay", {31'd0, sdo_seen[i]}, {31'd0, 1'(16'h1234 >> (31 - i))});

    send_bits(64'h00FF, 16);
    check("R3 mute right", {24'd0, g_r}, 32'h00);
    check("R3 full left", {24'd0, g_l}, 32'hFF);

    repeat (10) @(negedge clk);
    done = 1;
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      report();
    end
  end
endmodule